// File: doc/BRIEF.md
# Analog Channel Configuration Register File

This block holds the setup for a twelve-channel analog front end. It sits on a simple word-addressed bus that has one-cycle read and write strobes. It stores three kinds of setting:

- a data-stream enable bit;
- a direction bit for each channel;
- a two-bit input-range selector for each channel.

Every register keeps a shadow copy, which is the last value the bus wrote. The acquisition and output datapaths see a separate active copy.

The direction field acts at once: a write to it changes the active direction one clock later. The enable bit and the range selectors are held back. They reach the active set only when the `cfg_apply` strobe is pulsed, which happens at a device reset or at the start of an acquisition. That pulse copies every held-back setting in a single cycle. Reads always return the shadow value, so software sees what it wrote even before that value is active. Accesses beyond the last register are dropped. Such an access reads as zero and raises an error flag for one cycle.

Top module: `aio_cfg_regfile`

## Requirements
- R1: After `rst`, all of the following hold: every shadow register reads 0; `act_dir` is 0, so all channels are outputs; every `act_span` field is 0; `act_stream_en` equals the EN_POR parameter (default 0); `bus_rd_valid`, `bus_rdata` and `bus_err` are 0.
- R2: Address 0x00 keeps `bus_wdata` bit 0 as the stream enable, where 1 means enabled. A read returns that bit with all other bits 0. `act_stream_en` does not change until `cfg_apply`.
- R3: Address 0x01 keeps `bus_wdata[11:0]` as the direction field. Bit n is channel n, where 0 means output and 1 means input. `act_dir` shows the written value in the cycle after the write edge, with no `cfg_apply` needed. A read returns the field with bits 15:12 zero.
- R4: Address 0x02+n (n = 0..11) keeps `bus_wdata[1:0]` as the raw range code of channel n. A read returns that code with bits 15:2 zero.
- R5: A write to a range register leaves `act_span` unchanged until `cfg_apply`.
- R6: When `cfg_apply` is high at a clock edge, the enable bit and all twelve range codes are copied into the active set at that edge. The copy uses the shadow values held before the edge, so a write in the same cycle reaches only the shadow copy.
- R7: Field n of `act_span` sits at bits [2n+1:2n]. It encodes 00 = ±10 V, 01 = ±2.5 V, 10 = ±5 V. Raw code 3 is applied as 00, and 11 never appears.
- R8: A read strobed at an edge gives `bus_rd_valid` high with `bus_rdata` in the next cycle, for one cycle per strobe. `bus_rdata` is 0 whenever `bus_rd_valid` is low.
- R9: An access to an address above 0x0D has these effects: a write changes no register; a read returns 0 with `bus_rd_valid` set; `bus_err` is high in the cycle after that access edge.
- R10: A read and a write to the same address in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rd_valid | output | 1 | Read data valid |
| bus_err | output | 1 | Out-of-range access flag |
| cfg_apply | input | 1 | Copy the held-back settings to the active set |
| act_stream_en | output | 1 | Active stream enable |
| act_dir | output | 12 | Active direction, 1 = input |
| act_span | output | 24 | Active normalized range, two bits per channel |

## Verification
The results fall due as follows:

- A read's `bus_rd_valid`, `bus_rdata` and `bus_err` are due one edge after the strobe.
- `act_dir` is due one edge after a direction write.
- `act_stream_en` and `act_span` are due one edge after a `cfg_apply` edge.

Each bus access is driven on a falling edge. The driver queues the expected response at that point. A monitor samples 2 ns after the next rising edge, which is the only edge that could have produced the response, and any cycle with nothing queued must show an idle bus. The active outputs are compared against the bench's own shadow and active model on the falling edge that follows each access.

// File: rtl/aio_cfg_pkg.sv
package aio_cfg_pkg;
  // Normalized active span code
  typedef enum logic [1:0] {
    SPAN_10V  = 2'd0,
    SPAN_2V5  = 2'd1,
    SPAN_5V   = 2'd2
  } span_e;

  localparam int REG_EN     = 0;
  localparam int REG_DIR    = 1;
  localparam int RANGE_BASE = 2;

  // Raw code 3 is an alias of the widest span.
  function automatic logic [1:0] norm_span(input logic [1:0] code);
    return (code == 2'd3) ? SPAN_10V : code;
  endfunction
endpackage

// File: rtl/aio_cfg_decode.sv
module aio_cfg_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wr_sel,
  output logic              err
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NREG - 1);

  logic in_map;
  assign in_map = (addr <= LAST);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = wr_en && (addr == ADDR_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= (wr_en || rd_en) && !in_map;
  end

  // R9: at most one register strobed per write
  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/aio_cfg_shadow.sv
module aio_cfg_shadow
  import aio_cfg_pkg::*;
#(
  parameter int NCH     = 12,
  parameter int RANGE_W = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int NREG    = RANGE_BASE + NCH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREG-1:0]        wr_sel,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic                   sh_en,
  output logic [NCH-1:0]         sh_dir,
  output logic [NCH*RANGE_W-1:0] sh_rng_flat,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rd_valid
);
  logic [RANGE_W-1:0] sh_rng [NCH];
  logic [DATA_W-1:0]  rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_en  <= 1'b0;
      sh_dir <= '0;
    end else begin
      if (wr_sel[REG_EN])  sh_en  <= wdata[0];
      if (wr_sel[REG_DIR]) sh_dir <= wdata[NCH-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_rng
    always_ff @(posedge clk) begin
      if (rst)                         sh_rng[g] <= '0;
      else if (wr_sel[RANGE_BASE + g]) sh_rng[g] <= wdata[RANGE_W-1:0];
    end
    assign sh_rng_flat[g*RANGE_W +: RANGE_W] = sh_rng[g];
  end

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(REG_EN))  rd_word[0]     = sh_en;
    if (addr == ADDR_W'(REG_DIR)) rd_word[NCH-1:0] = sh_dir;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(RANGE_BASE + i)) rd_word[RANGE_W-1:0] = sh_rng[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? rd_word : '0;
    end
  end

  // R8: data bus quiet without a valid read
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rdata == '0));
  // R3: direction changes only through its own register
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_sel[REG_DIR] |=> $stable(sh_dir));
endmodule

// File: rtl/aio_cfg_active.sv
module aio_cfg_active
  import aio_cfg_pkg::*;
#(
  parameter int NCH     = 12,
  parameter int RANGE_W = 2,
  parameter bit EN_POR  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   apply,
  input  logic                   sh_en,
  input  logic [NCH*RANGE_W-1:0] sh_rng_flat,
  output logic                   act_en,
  output logic [NCH*RANGE_W-1:0] act_span
);
  always_ff @(posedge clk) begin
    if (rst)        act_en <= EN_POR;
    else if (apply) act_en <= sh_en;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_span
    always_ff @(posedge clk) begin
      if (rst)
        act_span[g*RANGE_W +: RANGE_W] <= SPAN_10V;
      else if (apply)
        act_span[g*RANGE_W +: RANGE_W] <= norm_span(sh_rng_flat[g*RANGE_W +: RANGE_W]);
    end

    // R7: the alias code never reaches the datapath
    p_span_legal_r7: assert property (@(posedge clk) disable iff (rst)
      act_span[g*RANGE_W +: RANGE_W] != 2'd3);
  end

  // R2: enable moves only on apply
  p_en_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(act_en));
  // R5: spans move only on apply
  p_span_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(act_span));
endmodule

// File: rtl/aio_cfg_regfile.sv
module aio_cfg_regfile
  import aio_cfg_pkg::*;
#(
  parameter int NCH     = 12,
  parameter int RANGE_W = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter bit EN_POR  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr_en,
  input  logic                   bus_rd_en,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_rd_valid,
  output logic                   bus_err,
  input  logic                   cfg_apply,
  output logic                   act_stream_en,
  output logic [NCH-1:0]         act_dir,
  output logic [NCH*RANGE_W-1:0] act_span
);
  localparam int NREG = RANGE_BASE + NCH;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NREG - 1);

  logic [NREG-1:0]        wr_sel;
  logic                   sh_en;
  logic [NCH*RANGE_W-1:0] sh_rng_flat;

  aio_cfg_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_decode (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wr_sel(wr_sel), .err(bus_err)
  );

  aio_cfg_shadow #(.NCH(NCH), .RANGE_W(RANGE_W), .ADDR_W(ADDR_W),
                   .DATA_W(DATA_W), .NREG(NREG)) u_shadow (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .sh_en(sh_en), .sh_dir(act_dir),
    .sh_rng_flat(sh_rng_flat), .rdata(bus_rdata), .rd_valid(bus_rd_valid)
  );

  aio_cfg_active #(.NCH(NCH), .RANGE_W(RANGE_W), .EN_POR(EN_POR)) u_active (
    .clk(clk), .rst(rst), .apply(cfg_apply), .sh_en(sh_en),
    .sh_rng_flat(sh_rng_flat), .act_en(act_stream_en), .act_span(act_span)
  );

  // R9: out-of-map write leaves the direction alone
  p_oob_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr > LAST) |=> $stable(act_dir));
  // R9: an error flag always follows a stray access
  p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past((bus_wr_en || bus_rd_en) && bus_addr > LAST));
  // R8: valid only answers a strobe
  p_rvalid_cause_r8: assert property (@(posedge clk) disable iff (rst)
    bus_rd_valid |-> $past(bus_rd_en));
endmodule

// File: tb/aio_cfg_regfile_bench.sv
module aio_cfg_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0, cfg_apply = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rd_valid, bus_err, act_stream_en;
  logic [11:0] act_dir;
  logic [23:0] act_span;

  aio_cfg_regfile u_aio_cfg_regfile (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd_valid(bus_rd_valid), .bus_err(bus_err), .cfg_apply(cfg_apply),
    .act_stream_en(act_stream_en), .act_dir(act_dir), .act_span(act_span)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          is_rd;
    logic [15:0] data;
    bit          err;
    string       req;
  } item_t;

  item_t       sbq[$];
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  logic        m_sh_en = 0, m_act_en = 0;
  logic [11:0] m_sh_dir = '0;
  logic [1:0]  m_sh_rng [12];
  logic [1:0]  m_act_span [12];

  function automatic logic [15:0] model_rd(input logic [7:0] a);
    if (a == 8'd0) return {15'd0, m_sh_en};
    if (a == 8'd1) return {4'd0, m_sh_dir};
    if (a <= 8'd13) return {14'd0, m_sh_rng[a-2]};
    return 16'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit wr, input bit rd, input logic [7:0] a,
                           input logic [15:0] d, input bit ap, input string req);
    item_t it;
    @(negedge clk);
    bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wdata = d; cfg_apply = ap;
    if (wr || rd) begin
      it.is_rd = rd;
      it.err   = (a > 8'd13);
      it.data  = rd ? model_rd(a) : 16'd0;
      it.req   = req;
      sbq.push_back(it);
    end
    if (ap) begin
      m_act_en = m_sh_en;
      for (int i = 0; i < 12; i++) m_act_span[i] = (m_sh_rng[i] == 2'd3) ? 2'd0 : m_sh_rng[i];
    end
    if (wr && a <= 8'd13) begin
      if (a == 8'd0)      m_sh_en = d[0];
      else if (a == 8'd1) m_sh_dir = d[11:0];
      else                m_sh_rng[a-2] = d[1:0];
    end
    @(negedge clk);
    bus_wr_en = 0; bus_rd_en = 0; cfg_apply = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic check_active(input string req);
    logic [23:0] exp_span;
    for (int i = 0; i < 12; i++) exp_span[2*i +: 2] = m_act_span[i];
    chk(act_stream_en === m_act_en, req, "act_stream_en", 32'(act_stream_en), 32'(m_act_en));
    chk(act_dir === m_sh_dir, req, "act_dir", 32'(act_dir), 32'(m_sh_dir));
    chk(act_span === exp_span, req, "act_span", 32'(act_span), 32'(exp_span));
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 14; a++) bus_cycle(0, 1, 8'(a), 16'd0, 0, req);
  endtask

  // Monitor: scoreboard pop just after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (!rst) begin
        if (sbq.size() > 0) begin
          it = sbq.pop_front();
          chk(bus_rd_valid === it.is_rd, it.req, "rd_valid", 32'(bus_rd_valid), 32'(it.is_rd));
          chk(bus_rdata === it.data, it.req, "rdata", 32'(bus_rdata), 32'(it.data));
          chk(bus_err === it.err, it.req, "err", 32'(bus_err), 32'(it.err));
        end else if (bus_rd_valid !== 1'b0 || bus_err !== 1'b0 || bus_rdata !== 16'd0) begin
          chk(0, "R8", "idle bus", {15'd0, bus_rd_valid, bus_rdata}, 32'd0);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) begin m_sh_rng[i] = 0; m_act_span[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    check_active("R1");
    chk(bus_rd_valid === 0 && bus_err === 0, "R1", "bus idle", {bus_rd_valid, bus_err}, 0);
    read_all("R1");

    // R2: enable held back
    bus_cycle(1, 0, 8'd0, 16'hFFFF, 0, "R2");
    check_active("R2");
    bus_cycle(0, 1, 8'd0, 16'd0, 0, "R2");

    // R3: direction immediate
    bus_cycle(1, 0, 8'd1, 16'hA5F3, 0, "R3");
    check_active("R3");
    bus_cycle(0, 1, 8'd1, 16'd0, 0, "R3");

    // R4 / R5: ranges written, junk in upper bits
    for (int n = 0; n < 12; n++) bus_cycle(1, 0, 8'(2 + n), 16'hFFFC | 16'(n % 4), 0, "R4");
    check_active("R5");
    read_all("R4");

    // R6 / R7: apply copies and normalizes
    bus_cycle(0, 0, 8'd0, 16'd0, 1, "R6");
    check_active("R7");

    // R6: write in apply cycle lands in shadow only
    bus_cycle(1, 0, 8'd2, 16'h0002, 1, "R6");
    check_active("R6");
    bus_cycle(1, 0, 8'd0, 16'h0000, 0, "R2");
    check_active("R2");
    bus_cycle(0, 0, 8'd0, 16'd0, 1, "R6");
    check_active("R6");

    // R9: stray accesses
    bus_cycle(1, 0, 8'd14, 16'hFFFF, 0, "R9");
    bus_cycle(1, 0, 8'hFF, 16'h0000, 0, "R9");
    check_active("R9");
    bus_cycle(0, 1, 8'h20, 16'd0, 0, "R9");
    read_all("R9");

    // R10: read-during-write
    bus_cycle(1, 1, 8'd1, 16'h0F0F, 0, "R10");
    bus_cycle(1, 1, 8'd5, 16'h0001, 0, "R10");
    bus_cycle(0, 1, 8'd1, 16'd0, 0, "R10");
    check_active("R3");

    // R3: all outputs again
    bus_cycle(1, 0, 8'd1, 16'h0000, 0, "R3");
    check_active("R3");
    bus_cycle(0, 0, 8'd0, 16'd0, 1, "R7");
    check_active("R7");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule